// File: doc/BRIEF.md
# Addressed Serial Stereo Volume Controller

This block is the digital control half of a two-channel volume attenuator. A host shifts 16-bit command words over three wires: a serial clock, a data line and a latch strobe. All three are treated as asynchronous and are resynchronized into the system clock. When the latch strobe rises, the block checks a two-bit chip address in the word against two strap inputs. Several controllers can therefore sit on one shared bus. On a match, a two-bit channel field chooses which of the left and right 8-bit attenuation registers take the word's code.

Each register is turned into a step index (0 to 80, one step per dB) and a mute flag. Codes above the top step saturate the index and raise mute. Every register write also produces a one-cycle strobe for the channel it touched. The analog signal path sits downstream and is driven from these outputs.

Top module: `svol_ctrl`

## Requirements
- R1: The command word is the last 16 data bits sampled on serial-clock rising edges before the latch, most significant bit first; any earlier bits are discarded.
- R2: A word takes effect only on a rising edge of the latch strobe, and only if at least 16 serial-clock rising edges have occurred since the previous latch edge or reset; otherwise the latch has no effect on any output.
- R3: Word bits 13 and 12 must equal strap_i[1] and strap_i[0] respectively, or the word is ignored; bits 15, 14, 11 and 10 have no effect.
- R4: Channel field bits 9:8 select the target: 00 both channels, 01 left only, 10 right only, 11 neither.
- R5: Bits 7:0 are the code. A channel's step output equals min(code, 80), and its mute output is 1 exactly when the code is in the range 0x51 to 0xFF.
- R6: While rst_n is low, and after it rises until the first accepted word, both channels hold code 0xFF: mute high, step 80, no strobes.
- R7: Each write to a channel raises that channel's update strobe for exactly one cycle, in the same cycle its new step and mute values appear. Without a strobe, the channel's outputs do not change.
- R8: When a serial-clock rising edge and a latch rising edge are seen in the same system cycle, the latch acts on the 16 bits held before that edge. The concurrent bit becomes the first bit counted toward the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sdat_i | input | 1 | Serial data from host (asynchronous) |
| slat_i | input | 1 | Latch strobe from host (asynchronous) |
| strap_i | input | 2 | Chip address straps; bit 1 pairs with word bit 13, bit 0 with word bit 12 |
| l_step_o | output | 7 | Left attenuation step index, 0..80 |
| l_mute_o | output | 1 | Left mute flag |
| l_upd_o | output | 1 | Left one-cycle update strobe |
| r_step_o | output | 7 | Right attenuation step index, 0..80 |
| r_mute_o | output | 1 | Right mute flag |
| r_upd_o | output | 1 | Right one-cycle update strobe |

## Verification
A serial-clock rising edge and a latch rising edge can be detected in the same system cycle. The word-count restart then collides with a shift. The bench provokes this by raising both host lines at the same instant, after a complete word. It judges the result in two steps. First, the outputs must reflect the word held before that edge. Second, a follow-on latch after only 15 further bits must be accepted, because the concurrent bit counts as the first of the new word.

// File: rtl/svol_pkg.sv
package svol_pkg;

   // Bit positions inside the command word that the decoder relies on.
   localparam int ADDR_LSB = 12;
   localparam int ADDR_W   = 2;
   localparam int SEL_LSB  = 8;
   localparam int CODE_LSB = 0;

   typedef enum logic [1:0] {
      SEL_BOTH  = 2'b00,
      SEL_LEFT  = 2'b01,
      SEL_RIGHT = 2'b10,
      SEL_NONE  = 2'b11
   } chan_sel_e;

   // Channel 0 is left, channel 1 is right.
   function automatic logic chan_hit(input chan_sel_e sel, input int ch);
      case (sel)
         SEL_BOTH:  return 1'b1;
         SEL_LEFT:  return (ch == 0);
         SEL_RIGHT: return (ch == 1);
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/svol_sync.sv
module svol_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] lvl_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("svol_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], async_i};
   end

   assign lvl_o = stg_q[STAGES-1];

endmodule

// File: rtl/svol_shift.sv
module svol_shift #(
   parameter int FRAME_W = 16,
   localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_lvl,
   input  logic               sdat_lvl,
   input  logic               slat_lvl,
   output logic [FRAME_W-1:0] frame_o,
   output logic               lat_rise_o,
   output logic               commit_o
);

   logic               sclk_q, slat_q;
   logic               sclk_rise;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;

   assign sclk_rise  = sclk_lvl & ~sclk_q;
   assign lat_rise_o = slat_lvl & ~slat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         slat_q <= 1'b0;
      end else begin
         sclk_q <= sclk_lvl;
         slat_q <= slat_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         shreg_q <= '0;
      else if (sclk_rise) shreg_q <= {shreg_q[FRAME_W-2:0], sdat_lvl};
   end

   // Edges since the last latch, saturating at one full word.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (lat_rise_o)
         cnt_q <= sclk_rise ? CNT_W'(1) : '0;
      else if (sclk_rise && (cnt_q != CNT_W'(FRAME_W)))
         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign frame_o  = shreg_q;
   assign commit_o = lat_rise_o && (cnt_q == CNT_W'(FRAME_W));

endmodule

// File: rtl/svol_decode.sv
module svol_decode
   import svol_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int CODE_W  = 8,
   parameter int NUM_CH  = 2
) (
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               commit_i,
   input  logic [ADDR_W-1:0]  strap_i,
   output logic [NUM_CH-1:0]  wr_o,
   output logic [CODE_W-1:0]  code_o
);

   if (ADDR_LSB + ADDR_W > FRAME_W) begin : g_bad_frame
      $error("svol_decode: address field outside the word");
   end
   if (CODE_LSB + CODE_W > SEL_LSB) begin : g_bad_code
      $error("svol_decode: code field overlaps the channel field");
   end

   chan_sel_e sel;
   logic      addr_hit;
   logic      dc_unused;

   assign sel       = chan_sel_e'(frame_i[SEL_LSB +: 2]);
   assign addr_hit  = (frame_i[ADDR_LSB +: ADDR_W] == strap_i);
   assign code_o    = frame_i[CODE_LSB +: CODE_W];
   assign dc_unused = ^{frame_i[FRAME_W-1:ADDR_LSB+ADDR_W], frame_i[ADDR_LSB-1:SEL_LSB+2]};

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_wr
      assign wr_o[ch] = commit_i && addr_hit && chan_hit(sel, ch);
   end

endmodule

// File: rtl/svol_chan.sv
module svol_chan #(
   parameter int          CODE_W     = 8,
   parameter int          MAX_STEP   = 80,
   parameter logic [CODE_W-1:0] RESET_CODE = '1,
   localparam int         STEP_W     = $clog2(MAX_STEP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [STEP_W-1:0] step_o,
   output logic              mute_o,
   output logic              upd_o
);

   localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_STEP);
   localparam logic [STEP_W-1:0] MAX_S = STEP_W'(MAX_STEP);

   logic [CODE_W-1:0] code_q;
   logic              upd_q;
   logic              over;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= RESET_CODE;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= wr_i;
         if (wr_i) code_q <= code_i;
      end
   end

   assign over   = (code_q > MAX_C);
   assign step_o = over ? MAX_S : code_q[STEP_W-1:0];
   assign mute_o = over;
   assign upd_o  = upd_q;

endmodule

// File: rtl/svol_ctrl.sv
module svol_ctrl #(
   parameter int  FRAME_W     = 16,
   parameter int  CODE_W      = 8,
   parameter int  MAX_STEP    = 80,
   parameter int  SYNC_STAGES = 2,
   localparam int STEP_W      = $clog2(MAX_STEP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic              slat_i,
   input  logic [1:0]        strap_i,
   output logic [STEP_W-1:0] l_step_o,
   output logic              l_mute_o,
   output logic              l_upd_o,
   output logic [STEP_W-1:0] r_step_o,
   output logic              r_mute_o,
   output logic              r_upd_o
);

   localparam int NUM_CH = 2;

   if (MAX_STEP >= (1 << CODE_W)) begin : g_bad_step
      $error("svol_ctrl: MAX_STEP must leave codes for mute");
   end

   logic [2:0]              lvl;
   logic [FRAME_W-1:0]      frame;
   logic                    lat_rise;
   logic                    commit;
   logic [NUM_CH-1:0]       wr;
   logic [CODE_W-1:0]       code;
   logic [NUM_CH-1:0][STEP_W-1:0] step;
   logic [NUM_CH-1:0]       mute;
   logic [NUM_CH-1:0]       upd;

   svol_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({slat_i, sdat_i, sclk_i}),
      .lvl_o   (lvl)
   );

   svol_shift #(.FRAME_W(FRAME_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_lvl   (lvl[0]),
      .sdat_lvl   (lvl[1]),
      .slat_lvl   (lvl[2]),
      .frame_o    (frame),
      .lat_rise_o (lat_rise),
      .commit_o   (commit)
   );

   svol_decode #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_dec (
      .frame_i  (frame),
      .commit_i (commit),
      .strap_i  (strap_i),
      .wr_o     (wr),
      .code_o   (code)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      svol_chan #(.CODE_W(CODE_W), .MAX_STEP(MAX_STEP)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_i   (wr[ch]),
         .code_i (code),
         .step_o (step[ch]),
         .mute_o (mute[ch]),
         .upd_o  (upd[ch])
      );
   end

   assign l_step_o = step[0];
   assign l_mute_o = mute[0];
   assign l_upd_o  = upd[0];
   assign r_step_o = step[1];
   assign r_mute_o = mute[1];
   assign r_upd_o  = upd[1];

endmodule

// File: rtl/svol_ctrl_chk.sv
module svol_ctrl_chk #(
   parameter int FRAME_W  = 16,
   parameter int STEP_W   = 7,
   parameter int MAX_STEP = 80
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         strap_i,
   input logic [FRAME_W-1:0] frame,
   input logic               lat_rise,
   input logic [STEP_W-1:0]  l_step_o,
   input logic               l_mute_o,
   input logic               l_upd_o,
   input logic [STEP_W-1:0]  r_step_o,
   input logic               r_mute_o,
   input logic               r_upd_o
);

   // R6
   reset_mute_chk: assert property (@(posedge clk)
      !rst_n |=> (l_mute_o && r_mute_o && !l_upd_o && !r_upd_o));

   // R5
   l_mute_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_mute_o |-> (l_step_o == STEP_W'(MAX_STEP)));

   // R5
   r_mute_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_mute_o |-> (r_step_o == STEP_W'(MAX_STEP)));

   // R7
   l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !l_upd_o |-> ($stable(l_step_o) && $stable(l_mute_o)));

   // R7
   r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !r_upd_o |-> ($stable(r_step_o) && $stable(r_mute_o)));

   // R7
   upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_upd_o || r_upd_o) |=> !(l_upd_o || r_upd_o));

   // R2
   upd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_upd_o || r_upd_o) |-> $past(lat_rise));

   // R3
   addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (l_upd_o || r_upd_o) |-> ($past(frame[13:12]) == $past(strap_i)));

   // R4
   l_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      l_upd_o |-> !$past(frame[9]));

   // R4
   r_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      r_upd_o |-> !$past(frame[8]));

endmodule

bind svol_ctrl svol_ctrl_chk #(.FRAME_W(FRAME_W), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .strap_i  (strap_i),
   .frame    (frame),
   .lat_rise (lat_rise),
   .l_step_o (l_step_o),
   .l_mute_o (l_mute_o),
   .l_upd_o  (l_upd_o),
   .r_step_o (r_step_o),
   .r_mute_o (r_mute_o),
   .r_upd_o  (r_upd_o)
);

// File: tb/sim_svol_ctrl.sv
module sim_svol_ctrl;

   logic       clk = 1'b0;
   logic       rst_n, sclk, sdat, slat;
   logic [1:0] strap;
   logic [6:0] l_step, r_step;
   logic       l_mute, r_mute, l_upd, r_upd;

   always #5 clk = ~clk;

   svol_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .slat_i(slat),
      .strap_i(strap), .l_step_o(l_step), .l_mute_o(l_mute), .l_upd_o(l_upd),
      .r_step_o(r_step), .r_mute_o(r_mute), .r_upd_o(r_upd)
   );

   int n_tests = 0, n_fail = 0;
   int l_cnt = 0, r_cnt = 0;
   logic [7:0]  e_l, e_r;
   logic [15:0] tb_shift;
   int          tb_cnt;
   int          l_base, r_base, exp_l_upd, exp_r_upd;

   always @(negedge clk) begin
      if (l_upd) l_cnt++;
      if (r_upd) r_cnt++;
   end

   function automatic int exp_step(logic [7:0] c);
      return (c > 8'd80) ? 80 : int'(c);
   endfunction

   function automatic int exp_mute(logic [7:0] c);
      return (c > 8'd80) ? 1 : 0;
   endfunction

   function automatic logic [15:0] mk(logic [1:0] adr, logic [1:0] sel, logic [7:0] code,
                                      logic [3:0] dc);
      return {dc[3:2], adr, dc[1:0], sel, code};
   endfunction

   task automatic chk(string what, int got, int exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic wait_clk(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(logic b);
      sdat = b;
      wait_clk(6);
      sclk = 1'b1;
      wait_clk(6);
      sclk = 1'b0;
      tb_shift = {tb_shift[14:0], b};
      if (tb_cnt < 16) tb_cnt++;
   endtask

   task automatic send_bits(logic [31:0] v, int n);
      for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   // Reference decision for a latch on the word the bench has shifted.
   task automatic model_latch();
      l_base = l_cnt;
      r_base = r_cnt;
      exp_l_upd = 0;
      exp_r_upd = 0;
      if (tb_cnt >= 16 && tb_shift[13:12] == strap) begin
         if (!tb_shift[9]) begin e_l = tb_shift[7:0]; exp_l_upd = 1; end
         if (!tb_shift[8]) begin e_r = tb_shift[7:0]; exp_r_upd = 1; end
      end
      tb_cnt = 0;
   endtask

   task automatic check_all(string tag);
      chk({tag, " R5 left step"},  int'(l_step), exp_step(e_l));
      chk({tag, " R5 left mute"},  int'(l_mute), exp_mute(e_l));
      chk({tag, " R5 right step"}, int'(r_step), exp_step(e_r));
      chk({tag, " R5 right mute"}, int'(r_mute), exp_mute(e_r));
      chk({tag, " R7 left strobes"},  l_cnt - l_base, exp_l_upd);
      chk({tag, " R7 right strobes"}, r_cnt - r_base, exp_r_upd);
   endtask

   task automatic do_latch(string tag);
      model_latch();
      wait_clk(3);
      slat = 1'b1;
      wait_clk(8);
      slat = 1'b0;
      wait_clk(4);
      check_all(tag);
   endtask

   task automatic frame_latch(logic [15:0] w, string tag);
      send_bits({16'h0, w}, 16);
      do_latch(tag);
   endtask

   // R8: serial rising edge and latch rising edge in the same instant.
   task automatic concurrent_latch(logic b, string tag);
      model_latch();
      sdat = b;
      wait_clk(6);
      sclk = 1'b1;
      slat = 1'b1;
      tb_shift = {tb_shift[14:0], b};
      tb_cnt = 1;
      wait_clk(6);
      sclk = 1'b0;
      wait_clk(3);
      slat = 1'b0;
      wait_clk(4);
      check_all(tag);
   endtask

   task automatic do_reset(string tag);
      rst_n = 1'b0;
      wait_clk(3);
      chk({tag, " R6 mute during reset"}, int'(l_mute & r_mute), 1);
      rst_n = 1'b1;
      e_l = 8'hFF;
      e_r = 8'hFF;
      tb_cnt = 0;
      l_base = l_cnt;
      r_base = r_cnt;
      exp_l_upd = 0;
      exp_r_upd = 0;
      wait_clk(4);
      check_all(tag);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd7321);
      rst_n = 1'b0; sclk = 1'b0; sdat = 1'b0; slat = 1'b0; strap = 2'b00;
      tb_shift = '0;
      wait_clk(2);
      do_reset("reset");

      frame_latch(mk(2'b00, 2'b00, 8'h00, 4'h0), "R4 both 0dB");
      frame_latch(mk(2'b00, 2'b01, 8'h50, 4'h0), "R4 left 0x50");
      frame_latch(mk(2'b00, 2'b10, 8'h51, 4'h0), "R4 right 0x51");
      frame_latch(mk(2'b00, 2'b11, 8'h10, 4'h0), "R4 select none");
      frame_latch(mk(2'b01, 2'b00, 8'h22, 4'h0), "R3 address mismatch");
      frame_latch(mk(2'b00, 2'b00, 8'h2A, 4'hF), "R3 dont-care bits set");
      send_bits(32'h3FF, 10);
      do_latch("R2 short word");
      send_bits(32'h2B, 6);
      frame_latch(mk(2'b00, 2'b10, 8'h07, 4'h0), "R1 extra leading bits");
      frame_latch(mk(2'b00, 2'b01, 8'hFF, 4'h0), "R5 code 0xFF");

      strap = 2'b10;
      frame_latch(mk(2'b10, 2'b00, 8'h33, 4'h5), "R3 strap 10 match");
      frame_latch(mk(2'b01, 2'b00, 8'h01, 4'h0), "R3 strap 10 mismatch");

      begin
         logic [15:0] b_word;
         send_bits({16'h0, mk(2'b10, 2'b01, 8'h44, 4'h0)}, 16);
         b_word = mk(2'b10, 2'b10, 8'h12, 4'h0);
         concurrent_latch(b_word[15], "R8 concurrent edge");
         send_bits({17'h0, b_word[14:0]}, 15);
         do_latch("R8 follow-on word");
      end

      for (int i = 0; i < 50; i++) begin
         logic [1:0] adr;
         int         extra;
         adr   = ($urandom_range(0, 3) != 0) ? strap : 2'($urandom_range(0, 3));
         extra = $urandom_range(0, 3);
         if (extra > 0) send_bits($urandom, extra);
         if ($urandom_range(0, 9) == 0) begin
            send_bits($urandom, $urandom_range(1, 15));
            do_latch("R2 random short");
         end else begin
            frame_latch(mk(adr, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
                           4'($urandom_range(0, 15))), "R1 random word");
         end
      end

      do_reset("R6 mid-run reset");
      frame_latch(mk(2'b10, 2'b00, 8'h50, 4'h0), "R5 after reset 0x50");

      summary();
      $finish;
   end

endmodule